// File: doc/BRIEF.md
# Live Insertion Transaction Gate

This block sits beside the forwarding engines of a two-port bus bridge and decides whether transactions may be forwarded while a card is being hot-inserted. It keeps the command enables (I/O space, memory space, bus master) and three control bits: a live-insertion mode bit, an output-enable bit for the insertion-control GPIO, and a secondary-bus reset bit. All of these sit behind a small configuration write/read port. An external insertion-control pin is brought through a two-flop synchronizer. When masking is armed and that pin is high, the effective enables sent to the target and master logic are forced low, while the stored values stay readable.

A three-state machine follows the masking condition and the occupancy of the posted-write and delayed-request queues, which enter only as counts. State `ST_RUN` forwards normally. State `ST_DRAIN` is masked while queued work is still outstanding. State `ST_HALT` is masked with both queues empty. The transitions are:
- `RUN->DRAIN` when the mask request is raised with work queued.
- `RUN->HALT` when the mask request is raised with both queues empty.
- `DRAIN->HALT` when both counts reach zero.
- `HALT->DRAIN` when a count becomes nonzero again.
- `DRAIN->RUN` and `HALT->RUN` when the mask request falls.

Software can watch `halted` and then pulse the secondary reset through the bridge control bit.

Top module: `hotplug_gate`

## Requirements
- R1: After primary reset every stored bit is 0, so `cfg_rdata` reads 0 at every address. All effective enables and `q_issue_en` are 0, `dc_ret_en` is 1, `halted` is 0 and `sec_rst_n` is 1.
- R2: Masking is armed only when the mode bit is 1 and the GPIO output-enable bit is 0 (input-only). With either condition missing, a high pin leaves each effective enable equal to its stored bit.
- R3: Armed masking with the pin high forces `eff_io_en`, `eff_mem_en`, `eff_mst_en` and `dc_ret_en` to 0. This takes effect at the third rising edge after the pin rises (two synchronizer stages plus the state register) and not before.
- R4: While masking is active, a read of address 0 returns the command bits as last written, not the masked values.
- R5: When the pin returns to 0, the effective enables again equal the stored command bits from the third rising edge after the fall, and `dc_ret_en` returns to 1.
- R6: `q_issue_en`, which lets queued posted writes and delayed requests complete as master, always equals the stored master bit, whether or not masking is active.
- R7: While masking is active, `halted` is 1 exactly when both `pw_cnt` and `dr_cnt` were zero at the previous edge. A nonzero count moves `ST_HALT` back to `ST_DRAIN`.
- R8: Configuration writes are accepted while masking is active. Clearing the mode bit releases the mask one rising edge after the edge that wrote it.
- R9: `sec_rst_n` is the inverse of the secondary-reset bit and changes at the edge that writes it.
- R10: Register map: address 0 holds the command bits (bit 0 I/O, bit 1 memory, bit 2 master), address 1 bit 0 is the mode bit, address 2 bit 0 is the GPIO output-enable (1 drives, 0 input-only), and address 3 bit 0 is the secondary reset. Unused bits read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Primary reset, active low |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register address |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_addr` |
| ins_gpio | input | 1 | Asynchronous insertion-control pin |
| pw_cnt | input | CW | Queued posted writes |
| dr_cnt | input | CW | Queued delayed requests |
| eff_io_en | output | 1 | Effective I/O space enable |
| eff_mem_en | output | 1 | Effective memory space enable |
| eff_mst_en | output | 1 | Effective bus master enable for new work |
| dc_ret_en | output | 1 | Delayed completions may be returned |
| q_issue_en | output | 1 | Already-queued master work may proceed |
| halted | output | 1 | Masked and both queues empty |
| sec_rst_n | output | 1 | Secondary bus reset, active low |

## Verification
The hardest situation to reach is `ST_HALT` re-entering `ST_DRAIN`. That needs masking armed, the pin already through the synchronizer, both queues drained, and then a count raised again while the pin stays high. The stimulus arms the mode and input-only bits first, raises the pin, and confirms that nothing changes for two edges. It then steps the queue counts one at a time, sampling after each edge. Configuration writes issued in the middle of this masked period show that readback and `q_issue_en` track the stored bits while the effective enables stay at zero.

// File: rtl/hpg_pkg.sv
package hpg_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_DRAIN = 2'd1,
        ST_HALT  = 2'd2
    } gate_st_t;

    localparam logic [1:0] A_CMD  = 2'd0;
    localparam logic [1:0] A_MODE = 2'd1;
    localparam logic [1:0] A_GDIR = 2'd2;
    localparam logic [1:0] A_BCTL = 2'd3;

    localparam int B_IO  = 0;
    localparam int B_MEM = 1;
    localparam int B_MST = 2;
endpackage

// File: rtl/hpg_sync.sv
module hpg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= d_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/hpg_regs.sv
module hpg_regs
    import hpg_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic [2:0]    cmd,
    output logic          live_mode,
    output logic          gpio_oe,
    output logic          sec_rst
);
    localparam int CMDW = 3;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd       <= '0;
            live_mode <= 1'b0;
            gpio_oe   <= 1'b0;
            sec_rst   <= 1'b0;
        end else if (we) begin
            unique case (addr)
                A_CMD:   cmd       <= wdata[CMDW-1:0];
                A_MODE:  live_mode <= wdata[0];
                A_GDIR:  gpio_oe   <= wdata[0];
                A_BCTL:  sec_rst   <= wdata[0];
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CMD:   rdata[CMDW-1:0] = cmd;
            A_MODE:  rdata[0]        = live_mode;
            A_GDIR:  rdata[0]        = gpio_oe;
            A_BCTL:  rdata[0]        = sec_rst;
            default: rdata           = '0;
        endcase
    end
endmodule

// File: rtl/hpg_fsm.sv
module hpg_fsm
    import hpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mask_req,
    input  logic       q_empty,
    input  logic [2:0] cmd,
    output logic       eff_io_en,
    output logic       eff_mem_en,
    output logic       eff_mst_en,
    output logic       dc_ret_en,
    output logic       q_issue_en,
    output logic       halted
);
    gate_st_t state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_RUN:   if (mask_req) nxt = q_empty ? ST_HALT : ST_DRAIN;
            ST_DRAIN: if (!mask_req) nxt = ST_RUN;
                      else if (q_empty) nxt = ST_HALT;
            ST_HALT:  if (!mask_req) nxt = ST_RUN;
                      else if (!q_empty) nxt = ST_DRAIN;
            default:  nxt = ST_RUN;
        endcase
    end

    always_comb begin
        eff_io_en  = 1'b0;
        eff_mem_en = 1'b0;
        eff_mst_en = 1'b0;
        dc_ret_en  = 1'b0;
        halted     = 1'b0;
        q_issue_en = cmd[B_MST];
        unique case (state)
            ST_RUN: begin
                eff_io_en  = cmd[B_IO];
                eff_mem_en = cmd[B_MEM];
                eff_mst_en = cmd[B_MST];
                dc_ret_en  = 1'b1;
            end
            ST_DRAIN: ;
            ST_HALT:  halted = 1'b1;
            default:  ;
        endcase
    end
endmodule

// File: rtl/hotplug_gate.sv
module hotplug_gate
    import hpg_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_addr,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_rdata,
    input  logic          ins_gpio,
    input  logic [CW-1:0] pw_cnt,
    input  logic [CW-1:0] dr_cnt,
    output logic          eff_io_en,
    output logic          eff_mem_en,
    output logic          eff_mst_en,
    output logic          dc_ret_en,
    output logic          q_issue_en,
    output logic          halted,
    output logic          sec_rst_n
);
    localparam int SYNC_STAGES = 2;

    logic [2:0] cmd;
    logic       live_mode, gpio_oe, sec_rst, gpio_s;
    logic       mask_req, q_empty;

    hpg_regs #(.DW(8), .AW(2)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .rdata(cfg_rdata), .cmd(cmd),
        .live_mode(live_mode), .gpio_oe(gpio_oe), .sec_rst(sec_rst)
    );

    hpg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ins_gpio), .d_out(gpio_s)
    );

    assign mask_req = live_mode & ~gpio_oe & gpio_s;
    assign q_empty  = (pw_cnt == '0) && (dr_cnt == '0);

    hpg_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .mask_req(mask_req), .q_empty(q_empty),
        .cmd(cmd), .eff_io_en(eff_io_en), .eff_mem_en(eff_mem_en),
        .eff_mst_en(eff_mst_en), .dc_ret_en(dc_ret_en),
        .q_issue_en(q_issue_en), .halted(halted)
    );

    assign sec_rst_n = ~sec_rst;
endmodule

// File: rtl/hpg_chk.sv
module hpg_chk #(
    parameter int CW = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_we,
    input logic [1:0]    cfg_addr,
    input logic [7:0]    cfg_wdata,
    input logic [7:0]    cfg_rdata,
    input logic [CW-1:0] pw_cnt,
    input logic [CW-1:0] dr_cnt,
    input logic          eff_io_en,
    input logic          eff_mem_en,
    input logic          eff_mst_en,
    input logic          dc_ret_en,
    input logic          q_issue_en,
    input logic          halted,
    input logic          sec_rst_n
);
    // R3
    masked_enables_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dc_ret_en |-> (!eff_io_en && !eff_mem_en && !eff_mst_en));

    // R4
    cmd_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd0) |=>
            (cfg_addr != 2'd0 || cfg_rdata[2:0] == $past(cfg_wdata[2:0])));

    // R6
    master_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eff_mst_en |-> q_issue_en);

    // R7
    halt_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> $past(pw_cnt == '0 && dr_cnt == '0));

    // R9
    sec_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == 2'd3) |=> (sec_rst_n == !$past(cfg_wdata[0])));
endmodule

bind hotplug_gate hpg_chk #(.CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pw_cnt(pw_cnt),
    .dr_cnt(dr_cnt), .eff_io_en(eff_io_en), .eff_mem_en(eff_mem_en),
    .eff_mst_en(eff_mst_en), .dc_ret_en(dc_ret_en),
    .q_issue_en(q_issue_en), .halted(halted), .sec_rst_n(sec_rst_n)
);

// File: tb/hotplug_gate_test.sv
module hotplug_gate_test;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_addr = 2'd0;
    logic [7:0]    cfg_wdata = 8'd0;
    logic [7:0]    cfg_rdata;
    logic          ins_gpio = 1'b0;
    logic [CW-1:0] pw_cnt = '0;
    logic [CW-1:0] dr_cnt = '0;
    logic eff_io_en, eff_mem_en, eff_mst_en, dc_ret_en, q_issue_en, halted, sec_rst_n;

    hotplug_gate #(.CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ins_gpio(ins_gpio),
        .pw_cnt(pw_cnt), .dr_cnt(dr_cnt), .eff_io_en(eff_io_en),
        .eff_mem_en(eff_mem_en), .eff_mst_en(eff_mst_en),
        .dc_ret_en(dc_ret_en), .q_issue_en(q_issue_en), .halted(halted),
        .sec_rst_n(sec_rst_n)
    );

    always #5 clk = ~clk;

    typedef struct {
        logic [14:0] exp;
        string       req;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_err = 0;
    bit    finished = 0;

    logic [2:0] m_cmd = 3'd0;
    logic       m_live = 1'b0, m_oe = 1'b0, m_sec = 1'b0;

    function automatic logic [14:0] model(input logic masked, input logic hlt);
        logic [7:0] rd;
        case (cfg_addr)
            2'd0:    rd = {5'd0, m_cmd};
            2'd1:    rd = {7'd0, m_live};
            2'd2:    rd = {7'd0, m_oe};
            default: rd = {7'd0, m_sec};
        endcase
        return {rd, m_cmd[0] & ~masked, m_cmd[1] & ~masked, m_cmd[2] & ~masked,
                ~masked, m_cmd[2], hlt, ~m_sec};
    endfunction

    // Driver side: push an expectation for the current sample point.
    task automatic expect_now(input logic masked, input logic hlt, input string req);
        item_t it;
        it.exp = model(masked, hlt);
        it.req = req;
        q.push_back(it);
    endtask

    // Monitor: compares outputs shortly after each falling edge.
    always @(negedge clk) begin
        #1;
        while (q.size() > 0) begin
            item_t it;
            logic [14:0] act;
            it  = q.pop_front();
            act = {cfg_rdata, eff_io_en, eff_mem_en, eff_mst_en, dc_ret_en,
                   q_issue_en, halted, sec_rst_n};
            n_chk++;
            if (act !== it.exp) begin
                n_err++;
                $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
            end
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0:    m_cmd  = d[2:0];
            2'd1:    m_live = d[0];
            2'd2:    m_oe   = d[0];
            default: m_sec  = d[0];
        endcase
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        step(3);
        expect_now(1'b0, 1'b0, "R1 reset state");
        step(1);
        rst_n = 1'b1;
        step(1);
        cfg_addr = 2'd3; #0;
        expect_now(1'b0, 1'b0, "R1 reset bctl reads 0");
        step(1);

        wr(2'd0, 8'h07); cfg_addr = 2'd0;
        expect_now(1'b0, 1'b0, "R10 command bits");
        step(1);

        ins_gpio = 1'b1; pw_cnt = 4'd2;
        step(4);
        expect_now(1'b0, 1'b0, "R2 mode off pin high");
        step(1);
        wr(2'd1, 8'h01); wr(2'd2, 8'h01); cfg_addr = 2'd0;
        step(2);
        expect_now(1'b0, 1'b0, "R2 output-enable set blocks arming");
        step(1);

        ins_gpio = 1'b0;
        step(3);
        wr(2'd2, 8'h00); cfg_addr = 2'd0;
        step(2);
        expect_now(1'b0, 1'b0, "R2 armed pin low");
        step(1);

        ins_gpio = 1'b1;
        step(2);
        expect_now(1'b0, 1'b0, "R3 no effect before third edge");
        step(1);
        expect_now(1'b1, 1'b0, "R3 masked at third edge, R4 readback, R6 drain");
        step(1);

        pw_cnt = 4'd0; dr_cnt = 4'd1;
        step(1);
        expect_now(1'b1, 1'b0, "R7 delayed request pending");
        dr_cnt = 4'd0;
        step(1);
        expect_now(1'b1, 1'b1, "R7 halted when empty");
        dr_cnt = 4'd3;
        step(1);
        expect_now(1'b1, 1'b0, "R7 halt back to drain");
        dr_cnt = 4'd0;
        step(1);
        expect_now(1'b1, 1'b1, "R7 halted again");
        step(1);

        wr(2'd0, 8'h05); cfg_addr = 2'd0;
        expect_now(1'b1, 1'b1, "R8 write accepted while masked R4");
        step(1);
        wr(2'd0, 8'h03); cfg_addr = 2'd0;
        expect_now(1'b1, 1'b1, "R6 master bit clear stops queue issue");
        step(1);

        wr(2'd3, 8'h01); cfg_addr = 2'd3;
        expect_now(1'b1, 1'b1, "R9 secondary reset asserted");
        step(1);
        wr(2'd3, 8'h00); cfg_addr = 2'd0;
        expect_now(1'b1, 1'b1, "R9 secondary reset released");
        step(1);

        ins_gpio = 1'b0;
        step(2);
        expect_now(1'b1, 1'b1, "R5 still masked before third edge");
        step(1);
        expect_now(1'b0, 1'b0, "R5 enables restored");
        step(1);

        ins_gpio = 1'b1;
        step(3);
        expect_now(1'b1, 1'b1, "R3 masked again");
        step(1);
        wr(2'd1, 8'h00); cfg_addr = 2'd0;
        expect_now(1'b1, 1'b1, "R8 mode clear not yet applied");
        step(1);
        expect_now(1'b0, 1'b0, "R8 mode clear releases mask");
        step(1);

        ins_gpio = 1'b0;
        step(3);
        wr(2'd1, 8'hFF); cfg_addr = 2'd1;
        expect_now(1'b0, 1'b0, "R10 unused mode bits read 0");
        step(1);
        wr(2'd2, 8'hFE); cfg_addr = 2'd2;
        expect_now(1'b0, 1'b0, "R10 unused direction bits ignored");
        step(2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule